// File: doc/BRIEF.md
# Paged Nonvolatile Write-Load Controller

This block is the write front end of a byte-wide, paged nonvolatile memory, modelled on a synchronous system clock. It watches already-sampled active-low chip-select, read-enable and write-strobe inputs together with a 15-bit address and an 8-bit data bus. It gathers the bytes of one page, up to 64 of them, into a local buffer, and each buffered byte carries a valid flag.

The load phase closes by itself once no further byte has arrived for a programmable number of cycles. The block then raises `busy` for a programmable programming time. During the first cycles of that time it presents every flagged byte, one per cycle, on a commit port that feeds an external behavioural array. Offsets that were never loaded are not presented, so they are never cycled.

Bytes may arrive in any order, and a byte may be rewritten before the commit. A byte aimed at a different page from the one opened by the first byte is dropped, and a sticky error flag records it. The programming time is set in clock cycles, and a parameter picks the standard length or the fast one.

Top module: `eeld_write_loader`

## Requirements
- R1: A byte is loaded only when `ce_n` and `we_n` are both low for at least FILT_CYC consecutive cycles and `oe_n` is high in every one of those cycles. A shorter low phase, a phase with `oe_n` low, and a `we_n` pulse while `ce_n` is high all load nothing.
- R2: The address is taken from the first cycle in which both strobes are low. The data is taken from the last cycle in which both strobes are low.
- R3: The page number is `addr[14:6]` and the byte offset is `addr[5:0]`. Once a load has started, a byte to another page is dropped and `page_err` goes to 1. `page_err` stays at 1 until reset.
- R4: The load phase ends WIN_CYC cycles after the last accepted byte completes. `busy` is first seen high at the (WIN_CYC+2)-th falling clock edge after the strobes rise.
- R5: `busy` stays high for exactly PROG_FAST_CYC cycles when FAST_PROG=1, and for exactly PROG_STD_CYC cycles otherwise.
- R6: While `busy` is high, `commit_valid` pulses once for each loaded offset, one per cycle, in ascending offset order. `commit_addr` carries {page, offset} and `commit_data` carries the byte. No pulse is produced for an offset that was not loaded.
- R7: Bytes may arrive in any offset order. If an offset is written twice in one load phase, the value written last is the one committed.
- R8: A strobe that completes while `busy` is high is ignored and produces no commit.
- R9: After reset, `busy`, `page_err` and `commit_valid` are 0 and the page buffer holds no flagged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, already synchronous |
| oe_n | input | 1 | Read enable, active low; a low level blocks writes |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 15 | Byte address: page in bits 14:6, offset in bits 5:0 |
| din | input | 8 | Write data |
| busy | output | 1 | High during the programming period |
| page_err | output | 1 | Sticky flag for a dropped byte aimed at another page |
| commit_valid | output | 1 | One byte is presented to the array this cycle |
| commit_addr | output | 15 | Address of the committed byte |
| commit_data | output | 8 | Value of the committed byte |

## Verification
A stale valid flag shows up in the next programming period as an extra commit at an offset nobody wrote. A lost flag shows up as a missing commit. Either one appears within 64 cycles of `busy` rising, and the scoreboard reports it as an unexpected or leftover entry. A window or programming counter that is off by one moves the rising or falling edge of `busy` by exactly one cycle, which the latency and length checks catch. A bad page latch shows up either in the page bits of `commit_addr` or as a `page_err` that rises without a mismatched strobe.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } seq_state_t;
endpackage

// File: rtl/eeld_strobe_qual.sv
// Qualifies combined strobe phases: address from the first low cycle, data
// from the last one, and a one-cycle load pulse when a valid phase ends.
module eeld_strobe_qual #(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int FILT_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              ld_valid,
   output logic [ADDR_W-1:0] ld_addr,
   output logic [DATA_W-1:0] ld_data
);
   localparam int FC_W = $clog2(FILT_CYC + 1);
   localparam logic [FC_W-1:0] FC_MAX = FC_W'(FILT_CYC);

   logic            active;
   logic            prev_active;
   logic            oe_bad;
   logic [FC_W-1:0] len_q;
   logic            phase_end;

   assign active    = ~ce_n & ~we_n;
   assign phase_end = prev_active & ~active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_active <= 1'b0;
         oe_bad      <= 1'b0;
         len_q       <= '0;
         ld_addr     <= '0;
         ld_data     <= '0;
         ld_valid    <= 1'b0;
      end else begin
         prev_active <= active;
         ld_valid    <= phase_end && (len_q >= FC_MAX) && !oe_bad;
         if (active) begin
            ld_data <= din;
            if (!prev_active) begin
               ld_addr <= addr;
               len_q   <= FC_W'(1);
               oe_bad  <= ~oe_n;
            end else begin
               if (len_q != FC_MAX) len_q <= len_q + FC_W'(1);
               oe_bad <= oe_bad | ~oe_n;
            end
         end
      end
   end
endmodule

// File: rtl/eeld_page_buf.sv
// One page of byte storage with a valid flag per byte.
module eeld_page_buf #(
   parameter int OFFSET_W = 6,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [OFFSET_W-1:0] wr_off,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                clr,
   input  logic [OFFSET_W-1:0] rd_off,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_vld
);
   localparam int NBYTES = 1 << OFFSET_W;

   logic [DATA_W-1:0] mem [NBYTES];
   logic [NBYTES-1:0] vld;

   for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[gi] <= 1'b0;
            mem[gi] <= '0;
         end else if (clr) begin
            vld[gi] <= 1'b0;
         end else if (wr_en && (wr_off == OFFSET_W'(gi))) begin
            vld[gi] <= 1'b1;
            mem[gi] <= wr_data;
         end
      end
   end

   assign rd_data = mem[rd_off];
   assign rd_vld  = vld[rd_off];
endmodule

// File: rtl/eeld_sequencer.sv
// Load window, programming timer, page latch and mismatch flag.
module eeld_sequencer
   import eeld_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int OFFSET_W = 6,
   parameter int WIN_CYC  = 7500,
   parameter int PCNT_W   = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic [ADDR_W-1:0]          ld_addr,
   input  logic [PCNT_W-1:0]          prog_last,
   output logic                       buf_wr_en,
   output logic                       buf_clr,
   output logic                       scan_on,
   output logic [OFFSET_W-1:0]        scan_off,
   output logic [ADDR_W-OFFSET_W-1:0] page_q,
   output logic                       busy,
   output logic                       page_err
);
   localparam int PAGE_W = ADDR_W - OFFSET_W;
   localparam int NBYTES = 1 << OFFSET_W;
   localparam int WC_W   = $clog2(WIN_CYC);
   localparam logic [WC_W-1:0] WIN_LAST = WC_W'(WIN_CYC - 1);

   seq_state_t        state;
   logic [WC_W-1:0]   win_cnt;
   logic [PCNT_W-1:0] prog_cnt;
   logic [PAGE_W-1:0] ld_page;
   logic              same_pg;
   logic              prog_done;

   assign ld_page   = ld_addr[ADDR_W-1:OFFSET_W];
   assign same_pg   = (ld_page == page_q);
   assign prog_done = (state == ST_PROG) && (prog_cnt == prog_last);
   assign buf_wr_en = ld_valid && ((state == ST_IDLE) || ((state == ST_LOAD) && same_pg));
   assign buf_clr   = prog_done;
   assign scan_on   = (state == ST_PROG) && (prog_cnt < PCNT_W'(NBYTES));
   assign scan_off  = prog_cnt[OFFSET_W-1:0];
   assign busy      = (state == ST_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         win_cnt  <= '0;
         prog_cnt <= '0;
         page_q   <= '0;
         page_err <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (ld_valid) begin
                  page_q  <= ld_page;
                  win_cnt <= '0;
                  state   <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (ld_valid && !same_pg) page_err <= 1'b1;
               if (ld_valid && same_pg) begin
                  win_cnt <= '0;
               end else if (win_cnt == WIN_LAST) begin
                  prog_cnt <= '0;
                  state    <= ST_PROG;
               end else begin
                  win_cnt <= win_cnt + WC_W'(1);
               end
            end
            ST_PROG: begin
               if (prog_done) state <= ST_IDLE;
               else           prog_cnt <= prog_cnt + PCNT_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eeld_write_loader.sv
module eeld_write_loader #(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int OFFSET_W      = 6,
   parameter int FILT_CYC      = 3,
   parameter int WIN_CYC       = 7500,
   parameter int PROG_STD_CYC  = 500000,
   parameter int PROG_FAST_CYC = 150000,
   parameter int FAST_PROG     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic              page_err,
   output logic              commit_valid,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int NBYTES   = 1 << OFFSET_W;
   localparam int PAGE_W   = ADDR_W - OFFSET_W;
   localparam int PROG_MAX = (PROG_STD_CYC > PROG_FAST_CYC) ? PROG_STD_CYC : PROG_FAST_CYC;
   localparam int PCNT_W   = $clog2(PROG_MAX + 1);

   if (OFFSET_W < 1 || OFFSET_W >= ADDR_W) begin : g_bad_offset
      $error("OFFSET_W must lie between 1 and ADDR_W-1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("FILT_CYC must be at least 1");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("WIN_CYC must be at least 2");
   end
   if (PROG_STD_CYC <= NBYTES || PROG_FAST_CYC <= NBYTES) begin : g_bad_prog
      $error("programming time must exceed the page size");
   end

   logic              ld_valid;
   logic [ADDR_W-1:0] ld_addr;
   logic [DATA_W-1:0] ld_data;
   logic              buf_wr_en;
   logic              buf_clr;
   logic              scan_on;
   logic [OFFSET_W-1:0] scan_off;
   logic [PAGE_W-1:0] page_q;
   logic [PCNT_W-1:0] prog_last;
   logic [DATA_W-1:0] rd_data;
   logic              rd_vld;

   if (FAST_PROG != 0) begin : g_fast
      assign prog_last = PCNT_W'(PROG_FAST_CYC - 1);
   end else begin : g_std
      assign prog_last = PCNT_W'(PROG_STD_CYC - 1);
   end

   eeld_strobe_qual #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC)
   ) i_qual (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   eeld_sequencer #(
      .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .WIN_CYC(WIN_CYC), .PCNT_W(PCNT_W)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .prog_last(prog_last), .buf_wr_en(buf_wr_en), .buf_clr(buf_clr),
      .scan_on(scan_on), .scan_off(scan_off), .page_q(page_q),
      .busy(busy), .page_err(page_err)
   );

   eeld_page_buf #(
      .OFFSET_W(OFFSET_W), .DATA_W(DATA_W)
   ) i_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(buf_wr_en),
      .wr_off(ld_addr[OFFSET_W-1:0]), .wr_data(ld_data), .clr(buf_clr),
      .rd_off(scan_off), .rd_data(rd_data), .rd_vld(rd_vld)
   );

   assign commit_valid = scan_on & rd_vld;
   assign commit_addr  = {page_q, scan_off};
   assign commit_data  = rd_data;
endmodule

// File: rtl/eeld_checks.sv
module eeld_checks #(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int OFFSET_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              page_err,
   input logic              commit_valid,
   input logic [ADDR_W-1:0] commit_addr,
   input logic [DATA_W-1:0] commit_data
);
   a_r9_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!busy && !commit_valid && !page_err));

   a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |=> page_err);

   a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> busy);

   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && $past(commit_valid)) |->
         (commit_addr[OFFSET_W-1:0] > $past(commit_addr[OFFSET_W-1:0])));

   a_r6_one_page: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && $past(commit_valid)) |->
         (commit_addr[ADDR_W-1:OFFSET_W] == $past(commit_addr[ADDR_W-1:OFFSET_W])));

   a_r5_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

   a_r6_data_known: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> !$isunknown(commit_data));
endmodule

bind eeld_write_loader eeld_checks #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W)
) i_eeld_checks (
   .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
   .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
);

// File: tb/test_eeld_write_loader.sv
module test_eeld_write_loader;
   localparam int FILT = 3;
   localparam int WIN  = 40;
   localparam int PSTD = 200;
   localparam int PFST = 90;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic        busy, page_err, commit_valid;
   logic [14:0] commit_addr;
   logic [7:0]  commit_data;

   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;
   logic [22:0] exp_q [$];
   int          busy_len = 0;
   int          last_busy_len = 0;
   int          busy_rises = 0;

   always #5 clk = ~clk;

   eeld_write_loader #(
      .FILT_CYC(FILT), .WIN_CYC(WIN), .PROG_STD_CYC(PSTD),
      .PROG_FAST_CYC(PFST), .FAST_PROG(1)
   ) i_eeld_write_loader (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .busy(busy), .page_err(page_err),
      .commit_valid(commit_valid), .commit_addr(commit_addr),
      .commit_data(commit_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [14:0] pa(input int page, input int off);
      return {9'(page), 6'(off)};
   endfunction

   // scoreboard monitor: commits against expected queue, busy length tracking
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (commit_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6/R8", "unexpected commit", int'({commit_addr, commit_data}), 0);
            end else begin
               logic [22:0] e;
               e = exp_q.pop_front();
               chk({commit_addr, commit_data} == e, "R6/R7", "commit {addr,data}",
                   int'({commit_addr, commit_data}), int'(e));
            end
         end
         if (busy) begin
            if (busy_len == 0) busy_rises++;
            busy_len++;
         end else if (busy_len != 0) begin
            last_busy_len = busy_len;
            busy_len = 0;
         end
      end
   end

   task automatic strobe(input logic [14:0] a, input logic [7:0] d, input int len,
                         input logic oe_low, input logic ce_high);
      @(negedge clk);
      addr = a; din = d; we_n = 1'b0; ce_n = ce_high; oe_n = ~oe_low;
      repeat (len - 1) @(negedge clk);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic strobe2(input logic [14:0] a1, input logic [7:0] d1,
                          input logic [14:0] a2, input logic [7:0] d2, input int len);
      @(negedge clk);
      addr = a1; din = d1; we_n = 1'b0; ce_n = 1'b0;
      @(negedge clk);
      addr = a2; din = d2;
      repeat (len - 2) @(negedge clk);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic push(input logic [14:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic wait_prog_end;
      int guard = 0;
      while (!busy && guard < 1000) begin @(negedge clk); guard++; end
      while (busy && guard < 2000) begin @(negedge clk); guard++; end
      @(negedge clk);
   endtask

   initial begin
      int lat;
      int rises0;
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(!busy, "R9", "busy after reset", busy, 0);
      chk(!page_err, "R9", "page_err after reset", page_err, 0);
      chk(!commit_valid, "R9", "commit_valid after reset", commit_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !commit_valid, "R9", "idle after release", busy, 0);

      // R7/R6: any order with overwrite on page 3, short gaps
      strobe(pa(3, 5), 8'hA1, 4, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      strobe(pa(3, 1), 8'hB2, 4, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      strobe(pa(3, 5), 8'hC3, 4, 1'b0, 1'b0);
      strobe(pa(3, 63), 8'hD4, 4, 1'b0, 1'b0);
      strobe(pa(3, 0), 8'hE5, 4, 1'b0, 1'b0);
      push(pa(3, 0), 8'hE5);
      push(pa(3, 1), 8'hB2);
      push(pa(3, 5), 8'hC3);
      push(pa(3, 63), 8'hD4);
      // R4: window latency from last strobe release
      lat = 0;
      while (!busy && lat < 200) begin @(negedge clk); lat++; end
      chk(lat == WIN + 2, "R4", "busy latency", lat, WIN + 2);
      // R8: strobe completing during programming is ignored
      strobe(pa(3, 10), 8'h77, 4, 1'b0, 1'b0);
      wait_prog_end();
      chk(last_busy_len == PFST, "R5", "busy length (fast option)", last_busy_len, PFST);
      chk(exp_q.size() == 0, "R6", "page 3 entries committed", exp_q.size(), 0);
      rises0 = busy_rises;
      repeat (WIN + 10) @(negedge clk);
      chk(busy_rises == rises0, "R8", "no load started by busy-time strobe", busy_rises, rises0);
      chk(!page_err, "R3", "no page error yet", page_err, 0);

      // R1: disqualified strobes
      strobe(pa(20, 0), 8'h01, FILT - 1, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      strobe(pa(20, 1), 8'h02, 5, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      strobe(pa(20, 2), 8'h03, 5, 1'b0, 1'b1);
      repeat (WIN + 10) @(negedge clk);
      chk(busy_rises == rises0, "R1", "blocked strobes start nothing", busy_rises, rises0);
      chk(!page_err, "R1", "blocked strobes latch no page", page_err, 0);

      // R2: address from first low cycle, data from last
      strobe2(pa(7, 2), 8'h11, pa(8, 9), 8'hC3, 5);
      repeat (3) @(negedge clk);
      // R3: other page dropped, sticky flag
      strobe(pa(9, 1), 8'h55, 4, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      chk(page_err, "R3", "page_err after mismatch", page_err, 1);
      push(pa(7, 2), 8'hC3);
      wait_prog_end();
      chk(exp_q.size() == 0, "R2", "captured byte committed", exp_q.size(), 0);
      chk(page_err, "R3", "page_err still set", page_err, 1);

      // R4: gap just inside the window merges, gap beyond splits
      rises0 = busy_rises;
      strobe(pa(1, 4), 8'h21, 3, 1'b0, 1'b0);
      repeat (WIN - 5) @(negedge clk);
      strobe(pa(1, 6), 8'h22, 3, 1'b0, 1'b0);
      push(pa(1, 4), 8'h21);
      push(pa(1, 6), 8'h22);
      wait_prog_end();
      chk(busy_rises == rises0 + 1, "R4", "near-window gap merges", busy_rises, rises0 + 1);
      strobe(pa(1, 9), 8'h33, 3, 1'b0, 1'b0);
      push(pa(1, 9), 8'h33);
      wait_prog_end();
      chk(busy_rises == rises0 + 2, "R4", "separate load phases", busy_rises, rises0 + 2);
      chk(exp_q.size() == 0, "R6", "all expected commits seen", exp_q.size(), 0);
      chk(last_busy_len == PFST, "R5", "busy length second run", last_busy_len, PFST);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule